// File: doc/BRIEF.md
# Shared-Datapath Sequential Floating Point Unit

This block adds, subtracts and multiplies floating point numbers using very little logic. It has one right-shifter for aligning operands and one leading-zero normalizer. Every operation passes through these two shifters, so the unit works on one operation at a time. A multi-state sequencer steps each operation through alignment (adds only), the mantissa arithmetic, normalization and a one-cycle completion state. Results are truncated. The unit produces no exception flags and has no special values.

Callers see a split interface. An add/subtract request strobe pairs with an add completion pulse and an add result port. A multiply request strobe pairs with a multiply completion pulse and a multiply result port. A client sequencer waits on the completion pulse of the operation it issued, so it does not depend on the latency. The same sequencer can therefore drive a pipelined unit that has the same pins.

Back-pressure is handled as follows. `busy` low is the unit's "ready to accept" indication. A request strobe is taken only in a cycle where `busy` is low, and a strobe raised while `busy` is high is dropped without effect. The completion pulses cannot be stalled. Each result port keeps its value until the next result of the same kind is written.

Top module: `fpu_seq_shared`

## Requirements
- R1: After reset, `busy`, `add_done` and `mul_done` are 0, and `add_result` and `mul_result` are all zeros.
- R2: Each operand and result is packed as {sign[MSB], exponent[EXP_W-1+MAN_W : MAN_W], mantissa[MAN_W-1:0]}. The exponent is two's complement. The value is (-1)^sign × mantissa/2^MAN_W × 2^exponent. A nonzero normalized mantissa has its top bit set, and zero is the all-zeros word.
- R3: A request is accepted only in a cycle where `busy` is low. A strobe raised while `busy` is high is ignored: it produces no completion and changes no result.
- R4: If `add_valid` and `mul_valid` are both high in an accepting cycle, the add is performed and the multiply request is dropped.
- R5: Count the clock edge that accepts a request as edge 0. For an add, `add_done` is high in the cycle that follows edge 3. For a multiply, `mul_done` is high in the cycle that follows edge 2. `busy` falls one cycle after the completion pulse.
- R6: Before an add, the operand with the smaller magnitude is shifted right by the exponent difference. Bits shifted out are lost, and a difference of MAN_W or more makes that operand zero.
- R7: When `add_sub` is 1 in the accepting cycle, the sign of the second operand is inverted, so the unit computes op_a − op_b.
- R8: When the effective signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger. An exact zero sum is returned as the all-zeros word (positive).
- R9: A product's sign is the XOR of the operand signs. Its exponent is the sum of the operand exponents minus the normalization shift. Its mantissa is the top MAN_W bits of the normalized double-width product, truncated.
- R10: A nonzero result always has its mantissa top bit set. The normalizer removes all leading zeros and lowers the exponent by the same count.
- R11: Only an add writes `add_result`, and only a multiply writes `mul_result`. Each result holds its value between writes.
- R12: Each completion pulse lasts exactly one cycle, and the two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| add_valid | input | 1 | Add/subtract request strobe |
| add_sub | input | 1 | 1 selects subtraction for the add request |
| mul_valid | input | 1 | Multiply request strobe |
| op_a | input | 1+EXP_W+MAN_W | First operand |
| op_b | input | 1+EXP_W+MAN_W | Second operand |
| busy | output | 1 | Operation in flight; low means a request is accepted |
| add_done | output | 1 | One-cycle pulse: `add_result` is new |
| add_result | output | 1+EXP_W+MAN_W | Last add/subtract result |
| mul_done | output | 1 | One-cycle pulse: `mul_result` is new |
| mul_result | output | 1+EXP_W+MAN_W | Last multiply result |

## Verification
Two cases can collide in one cycle. The first is an add request and a multiply request raised together on an idle unit. The bench raises both strobes in the same cycle and checks three things: only `add_done` pulses, at add latency and with the correct sum, and `mul_result` keeps its earlier value. The second is a new request arriving while an operation is in flight. The bench raises a multiply strobe in the cycle after an add was accepted. It then checks that the add still completes on time, that no multiply completion appears, and that the multiply result is unchanged.

// File: rtl/fpu_seq_pkg.sv
package fpu_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ALIGN   = 3'd1,
    ST_COMPUTE = 3'd2,
    ST_NORM    = 3'd3,
    ST_DONE    = 3'd4
  } fpu_state_t;

  typedef enum logic {
    OPK_ADD = 1'b0,
    OPK_MUL = 1'b1
  } fpu_opk_t;

endpackage

// File: rtl/fpu_mag_order.sv
// Decides which add operand has the larger magnitude (zero is always smaller).
module fpu_mag_order #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic [EXP_W-1:0] a_exp,
  input  logic [MAN_W-1:0] a_man,
  input  logic [EXP_W-1:0] b_exp,
  input  logic [MAN_W-1:0] b_man,
  output logic             b_larger
);
  logic a_zero, b_zero;

  always_comb begin
    a_zero = (a_man == '0);
    b_zero = (b_man == '0);
    if (a_zero)                                  b_larger = 1'b1;
    else if (b_zero)                             b_larger = 1'b0;
    else if ($signed(b_exp) > $signed(a_exp))    b_larger = 1'b1;
    else if (b_exp == a_exp && b_man > a_man)    b_larger = 1'b1;
    else                                         b_larger = 1'b0;
  end
endmodule

// File: rtl/fpu_denorm.sv
// The single right shifter: aligns a mantissa to a larger exponent, truncating.
module fpu_denorm #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic [MAN_W-1:0] man_in,
  input  logic [EXP_W:0]   shift,
  output logic [MAN_W-1:0] man_out
);
  localparam logic [EXP_W:0] SHIFT_LIMIT = (EXP_W+1)'(MAN_W);

  always_comb begin
    if (shift >= SHIFT_LIMIT) man_out = '0;
    else                      man_out = man_in >> shift;
  end
endmodule

// File: rtl/fpu_norm.sv
// The single normalizer: strips leading zeros from a wide word.
// Word value is word_in/2^WORD_W * 2^exp_in.
module fpu_norm #(
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 16,
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [EXP_W-1:0]  exp_in,
  output logic [MAN_W-1:0]  man_out,
  output logic [EXP_W-1:0]  exp_out,
  output logic              is_zero
);
  localparam int LZ_W = $clog2(WORD_W + 1);

  logic [LZ_W-1:0]   lz;
  logic              found;
  logic [WORD_W-1:0] shifted;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (word_in[i]) found = 1'b1;
        else            lz    = lz + LZ_W'(1);
      end
    end
    is_zero = !found;
    shifted = word_in << lz;
    if (is_zero) begin
      man_out = '0;
      exp_out = '0;
    end else begin
      man_out = shifted[WORD_W-1 -: MAN_W];
      exp_out = exp_in - EXP_W'(lz);
    end
  end
endmodule

// File: rtl/fpu_seq_shared.sv
module fpu_seq_shared
  import fpu_seq_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     add_valid,
  input  logic                     add_sub,
  input  logic                     mul_valid,
  input  logic [EXP_W+MAN_W:0]     op_a,
  input  logic [EXP_W+MAN_W:0]     op_b,
  output logic                     busy,
  output logic                     add_done,
  output logic [EXP_W+MAN_W:0]     add_result,
  output logic                     mul_done,
  output logic [EXP_W+MAN_W:0]     mul_result
);
  localparam int FW     = 1 + EXP_W + MAN_W;
  localparam int WORD_W = 2 * MAN_W;

  // operand fields
  logic             a_s, b_s, b_eff_s;
  logic [EXP_W-1:0] a_e, b_e;
  logic [MAN_W-1:0] a_m, b_m;
  assign a_s     = op_a[FW-1];
  assign a_e     = op_a[FW-2 -: EXP_W];
  assign a_m     = op_a[MAN_W-1:0];
  assign b_s     = op_b[FW-1];
  assign b_e     = op_b[FW-2 -: EXP_W];
  assign b_m     = op_b[MAN_W-1:0];
  assign b_eff_s = b_s ^ add_sub;

  fpu_state_t       st;
  fpu_opk_t         opk;
  logic             big_s, signs_differ;
  logic [EXP_W-1:0] big_e, sml_e;
  logic [MAN_W-1:0] big_m, sml_m;
  logic [WORD_W-1:0] wrd;
  logic [EXP_W-1:0]  wexp;
  logic [FW-1:0]     add_res_q, mul_res_q;

  logic             b_larger;
  logic [EXP_W:0]   exp_gap;
  logic [MAN_W-1:0] sml_aligned;
  logic [MAN_W-1:0] nrm_man;
  logic [EXP_W-1:0] nrm_exp;
  logic             nrm_zero;
  logic [MAN_W:0]   mag_sum;

  fpu_mag_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
    .a_exp(a_e), .a_man(a_m), .b_exp(b_e), .b_man(b_m), .b_larger(b_larger)
  );

  assign exp_gap = {big_e[EXP_W-1], big_e} - {sml_e[EXP_W-1], sml_e};

  fpu_denorm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_denorm (
    .man_in(sml_m), .shift(exp_gap), .man_out(sml_aligned)
  );

  fpu_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W), .WORD_W(WORD_W)) u_norm (
    .word_in(wrd), .exp_in(wexp), .man_out(nrm_man), .exp_out(nrm_exp),
    .is_zero(nrm_zero)
  );

  assign mag_sum = signs_differ ? ({1'b0, big_m} - {1'b0, sml_m})
                                : ({1'b0, big_m} + {1'b0, sml_m});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      opk          <= OPK_ADD;
      big_s        <= 1'b0;
      signs_differ <= 1'b0;
      big_e        <= '0;
      sml_e        <= '0;
      big_m        <= '0;
      sml_m        <= '0;
      wrd          <= '0;
      wexp         <= '0;
      add_res_q    <= '0;
      mul_res_q    <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (add_valid) begin
            opk          <= OPK_ADD;
            signs_differ <= a_s ^ b_eff_s;
            if (b_larger) begin
              big_s <= b_eff_s; big_e <= b_e; big_m <= b_m;
              sml_e <= a_e;     sml_m <= a_m;
            end else begin
              big_s <= a_s;     big_e <= a_e; big_m <= a_m;
              sml_e <= b_e;     sml_m <= b_m;
            end
            st <= ST_ALIGN;
          end else if (mul_valid) begin
            opk   <= OPK_MUL;
            big_s <= a_s ^ b_s;
            big_e <= a_e; big_m <= a_m;
            sml_e <= b_e; sml_m <= b_m;
            st    <= ST_COMPUTE;
          end
        end
        ST_ALIGN: begin
          sml_m <= sml_aligned;
          st    <= ST_COMPUTE;
        end
        ST_COMPUTE: begin
          if (opk == OPK_ADD) begin
            wrd  <= {mag_sum, {(MAN_W-1){1'b0}}};
            wexp <= big_e + EXP_W'(1);
          end else begin
            wrd  <= WORD_W'(big_m) * WORD_W'(sml_m);
            wexp <= big_e + sml_e;
          end
          st <= ST_NORM;
        end
        ST_NORM: begin
          if (opk == OPK_ADD) add_res_q <= {big_s & ~nrm_zero, nrm_exp, nrm_man};
          else                mul_res_q <= {big_s & ~nrm_zero, nrm_exp, nrm_man};
          st <= ST_DONE;
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st != ST_IDLE);
  assign add_done   = (st == ST_DONE) && (opk == OPK_ADD);
  assign mul_done   = (st == ST_DONE) && (opk == OPK_MUL);
  assign add_result = add_res_q;
  assign mul_result = mul_res_q;

  // ---------------- assertions ----------------
  assert_add_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    add_done |=> !add_done);
  assert_mul_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mul_done |=> !mul_done);
  assert_single_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({add_done, mul_done}));
  assert_inflight_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !add_done && !mul_done) |=> ($stable(opk) && busy));
  assert_add_normalized_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (add_done && add_result[MAN_W-1:0] != '0) |-> add_result[MAN_W-1]);
  assert_mul_normalized_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_done && mul_result[MAN_W-1:0] != '0) |-> mul_result[MAN_W-1]);
  assert_zero_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (add_done && add_result[MAN_W-1:0] == '0) |-> (add_result == '0));
  assert_mul_untouched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    add_done |-> $stable(mul_result));
  assert_align_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ALIGN && exp_gap >= (EXP_W+1)'(MAN_W)) |=> (sml_m == '0));
endmodule

// File: tb/fpu_seq_shared_tb.sv
module fpu_seq_shared_tb;
  localparam int EXP_W = 8;
  localparam int MAN_W = 16;
  localparam int FW    = 1 + EXP_W + MAN_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          add_valid = 1'b0, add_sub = 1'b0, mul_valid = 1'b0;
  logic [FW-1:0] op_a = '0, op_b = '0;
  logic          busy, add_done, mul_done;
  logic [FW-1:0] add_result, mul_result;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  fpu_seq_shared #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .add_valid(add_valid), .add_sub(add_sub),
    .mul_valid(mul_valid), .op_a(op_a), .op_b(op_b), .busy(busy),
    .add_done(add_done), .add_result(add_result),
    .mul_done(mul_done), .mul_result(mul_result)
  );

  function automatic logic [FW-1:0] fp(input logic s, input int e, input logic [MAN_W-1:0] m);
    return {s, EXP_W'(e), m};
  endfunction

  task automatic check(input bit ok, input string req, input logic [FW-1:0] act,
                       input logic [FW-1:0] expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  // Issue one request cycle, then observe 8 cycles at negedges.
  task automatic issue(input logic av, input logic sv, input logic mv,
                       input logic [FW-1:0] a, input logic [FW-1:0] b,
                       input bit late_mul,
                       output int add_at, output int mul_at, output int idle_at);
    @(negedge clk);
    add_valid = av; add_sub = sv; mul_valid = mv; op_a = a; op_b = b;
    @(negedge clk);
    add_valid = 1'b0; mul_valid = late_mul;
    add_at = 0; mul_at = 0; idle_at = 0;
    for (int i = 1; i <= 8; i++) begin
      if (i > 1) @(negedge clk);
      if (i == 2) mul_valid = 1'b0;
      if (add_done && add_at == 0) add_at = i;
      if (mul_done && mul_at == 0) mul_at = i;
      if (!busy && idle_at == 0)   idle_at = i;
    end
  endtask

  task automatic run_add(input logic [FW-1:0] a, input logic [FW-1:0] b, input logic sub,
                         input logic [FW-1:0] expv, input string req);
    int aa, ma, ia;
    logic [FW-1:0] mul_before;
    mul_before = mul_result;
    issue(1'b1, sub, 1'b0, a, b, 1'b0, aa, ma, ia);
    check(add_result == expv, req, add_result, expv);
    check(aa == 4 && ia == 5, "R5 add latency", FW'(aa), FW'(4));
    check(ma == 0 && mul_result == mul_before, "R11 mul untouched by add",
          mul_result, mul_before);
  endtask

  task automatic run_mul(input logic [FW-1:0] a, input logic [FW-1:0] b,
                         input logic [FW-1:0] expv, input string req);
    int aa, ma, ia;
    logic [FW-1:0] add_before;
    add_before = add_result;
    issue(1'b0, 1'b0, 1'b1, a, b, 1'b0, aa, ma, ia);
    check(mul_result == expv, req, mul_result, expv);
    check(ma == 3 && ia == 4, "R5 mul latency", FW'(ma), FW'(3));
    check(aa == 0 && add_result == add_before, "R11 add untouched by mul",
          add_result, add_before);
  endtask

  task automatic t_reset;
    check(!busy && !add_done && !mul_done, "R1 flags", FW'({busy, add_done, mul_done}), '0);
    check(add_result == '0 && mul_result == '0, "R1 results", add_result | mul_result, '0);
  endtask

  task automatic t_add_basic;
    run_add(fp(0, 1, 16'h8000), fp(0, 1, 16'h8000), 1'b0, fp(0, 2, 16'h8000), "R2 1+1");
    run_add(fp(0, 2, 16'hC000), fp(0, 1, 16'h8000), 1'b0, fp(0, 3, 16'h8000), "R6 3+1");
    run_add('0, fp(0, 2, 16'hC000), 1'b0, fp(0, 2, 16'hC000), "R6 0+3");
  endtask

  task automatic t_align_trunc;
    run_add(fp(0, 1, 16'h8001), fp(0, 0, 16'h8001), 1'b0, fp(0, 1, 16'hC001), "R6 truncating shift");
    run_add(fp(0, 1, 16'h8000), fp(0, -20, 16'hFFFF), 1'b0, fp(0, 1, 16'h8000), "R6 shift past width");
  endtask

  task automatic t_subtract;
    run_add(fp(0, 1, 16'h8000), fp(0, 1, 16'h8000), 1'b1, '0, "R8 exact zero");
    run_add(fp(0, 1, 16'h8000), fp(0, 2, 16'hC000), 1'b1, fp(1, 2, 16'h8000), "R7 1-3");
    run_add(fp(1, 2, 16'hC000), fp(0, 1, 16'h8000), 1'b0, fp(1, 2, 16'h8000), "R8 -3+1");
    run_add(fp(1, 1, 16'h8000), fp(1, 2, 16'hC000), 1'b1, fp(0, 2, 16'h8000), "R7 -1-(-3)");
  endtask

  task automatic t_multiply;
    run_mul(fp(0, 2, 16'hC000), fp(1, 2, 16'hC000), fp(1, 4, 16'h9000), "R9 3*-3");
    run_mul(fp(0, 0, 16'h8000), fp(0, 0, 16'h8000), fp(0, -1, 16'h8000), "R10 0.5*0.5");
    run_mul(fp(0, 0, 16'hFFFF), fp(0, 0, 16'hFFFF), fp(0, 0, 16'hFFFE), "R9 truncation");
    run_mul('0, fp(1, 2, 16'hC000), '0, "R9 times zero");
  endtask

  task automatic t_busy_drop;
    int aa, ma, ia;
    logic [FW-1:0] mul_before;
    mul_before = mul_result;
    issue(1'b1, 1'b0, 1'b0, fp(0, 1, 16'h8000), fp(0, 1, 16'h8000), 1'b1, aa, ma, ia);
    check(ma == 0 && mul_result == mul_before, "R3 request while busy", mul_result, mul_before);
    check(aa == 4 && add_result == fp(0, 2, 16'h8000), "R3 add unaffected",
          add_result, fp(0, 2, 16'h8000));
  endtask

  task automatic t_both_req;
    int aa, ma, ia;
    logic [FW-1:0] mul_before;
    mul_before = mul_result;
    issue(1'b1, 1'b0, 1'b1, fp(0, 2, 16'hC000), fp(0, 2, 16'hC000), 1'b0, aa, ma, ia);
    check(aa == 4 && add_result == fp(0, 3, 16'hC000), "R4 add wins", add_result,
          fp(0, 3, 16'hC000));
    check(ma == 0 && mul_result == mul_before, "R4 mul dropped", mul_result, mul_before);
  endtask

  task automatic t_pulse_width;
    int hi;
    hi = 0;
    @(negedge clk);
    add_valid = 1'b1; op_a = fp(0, 1, 16'h8000); op_b = fp(0, 1, 16'h8000);
    @(negedge clk);
    add_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      if (add_done) hi++;
      if (add_done && mul_done) hi = 99;
    end
    check(hi == 1, "R12 single-cycle pulse", FW'(hi), FW'(1));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add_basic();
    t_align_trunc();
    t_subtract();
    t_multiply();
    t_busy_drop();
    t_both_req();
    t_pulse_width();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule